// File: doc/BRIEF.md
# Stochastic Tsetlin Automaton Bank

This block holds an addressable array of small learning automata. Each automaton stands in for one binary table entry of a weightless classifier. Each automaton is a saturating counter with 2N states. Its output bit, the action, is 1 when the counter sits in the upper half. A combinational read port returns the action at any address. This lets a classifier's lookup path query the bank the same way it would query a plain bit table.

Training traffic comes in on two request channels, one that rewards (increments) and one that penalises (decrements). Each channel carries its own address. A request takes effect only when a pseudo-random draw falls below a programmable feedback probability. The two channels draw from separate slices of an on-chip shift-register generator, so each decision is made independently. The controller above this block decides which class is rewarded or penalised and which addresses take part; the bank only applies the requests it is given.

Top module: `ta_bank`

## Requirements
- R1: While and after reset, every automaton holds state N, the midpoint of its range, so every address reads an action of 0 before any update.
- R2: The action read at `rd_addr` is 1 exactly when that automaton's state is above N. State N reads 0 and state N+1 reads 1. The read is combinational and reflects an update in the cycle after the clock edge that applied it.
- R3: An applied increment raises the addressed state by one.
- R4: An applied decrement lowers the addressed state by one.
- R5: The state saturates at 2N. Further increments leave it at 2N, with no wraparound.
- R6: The state saturates at 1. Further decrements leave it at 1, with no wraparound.
- R7: When `fb_prob` is 0, no request on either channel changes any state.
- R8: A request is applied only when its random draw, read as an unsigned PROB_W-bit value, is strictly below `fb_prob`. `fb_prob` is PROB_W+1 bits wide, so the value 2^PROB_W applies every request and 2^(PROB_W-1) applies about half of them.
- R9: An increment and a decrement to the same address in the same cycle cancel. That state is unchanged whatever the draws.
- R10: An increment and a decrement to different addresses in the same cycle are both applied, each gated by its own draw.
- R11: The random generator leaves reset at a non-zero seed and moves to a new value on every clock cycle.
- R12: An update changes only the automaton at its address. All other states stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_prob | input | PROB_W+1 | Feedback probability, as a fraction of 2^PROB_W |
| rd_addr | input | AW | Address of the automaton to read |
| rd_act | output | 1 | Action of the automaton at `rd_addr` |
| inc_req | input | 1 | Increment request valid |
| inc_addr | input | AW | Increment target address |
| dec_req | input | 1 | Decrement request valid |
| dec_addr | input | AW | Decrement target address |

## Verification
Single increments and decrements at full probability, starting from the midpoint, check the output threshold. They show the difference between state N and state N+1, and whether a step was lost or doubled. Long runs of one-sided requests followed by counted steps back check saturation at each end. A counter that wraps or overshoots would leave the action flipping one step early or late. Paired requests, first to one address and then to two different addresses, separate cancellation from independent application. A repeated single-step trial at half probability shows that the random gate lets through some requests but not all of them.

// File: rtl/ta_pkg.sv
package ta_pkg;
   // Right-shift Galois feedback masks for maximal-length sequences.
   function automatic logic [31:0] lfsr_mask(input int w);
      case (w)
         8:       return 32'h0000_00B8;
         16:      return 32'h0000_B400;
         24:      return 32'h00E1_0000;
         32:      return 32'h8020_0003;
         default: return 32'h0000_0000;
      endcase
   endfunction

   function automatic bit lfsr_width_ok(input int w);
      return (w == 8) || (w == 16) || (w == 24) || (w == 32);
   endfunction
endpackage

// File: rtl/ta_lfsr.sv
module ta_lfsr #(
   parameter int          WIDTH = 16,
   parameter logic [31:0] SEED  = 32'h0000_ACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [WIDTH-1:0] rnd
);
   import ta_pkg::*;

   localparam logic [WIDTH-1:0] MASK  = WIDTH'(lfsr_mask(WIDTH));
   localparam logic [WIDTH-1:0] SEEDW = WIDTH'(SEED);

   if (!lfsr_width_ok(WIDTH)) begin : g_bad_width
      $error("ta_lfsr: WIDTH must be 8, 16, 24 or 32");
   end
   if (SEEDW == '0) begin : g_bad_seed
      $error("ta_lfsr: SEED must be non-zero within WIDTH bits");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rnd <= SEEDW;
      else        rnd <= (rnd >> 1) ^ (rnd[0] ? MASK : '0);
   end
endmodule

// File: rtl/ta_gate.sv
module ta_gate #(
   parameter int PROB_W = 8
) (
   input  logic [PROB_W-1:0] draw,
   input  logic [PROB_W:0]   prob,
   input  logic              req,
   output logic              pass
);
   always_comb pass = req && ({1'b0, draw} < prob);
endmodule

// File: rtl/ta_cell.sv
module ta_cell #(
   parameter int HALF = 64,
   parameter int SW   = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          up,
   input  logic          dn,
   output logic [SW-1:0] st,
   output logic          act
);
   localparam logic [SW-1:0] MID = SW'(HALF);
   localparam logic [SW-1:0] TOP = SW'(2 * HALF);
   localparam logic [SW-1:0] BOT = SW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)                         st <= MID;
      else if (up && !dn && st != TOP)    st <= st + SW'(1);
      else if (dn && !up && st != BOT)    st <= st - SW'(1);
   end

   always_comb act = (st > MID);
endmodule

// File: rtl/ta_bank.sv
module ta_bank #(
   parameter int          NUM_TA = 32,
   parameter int          HALF   = 64,
   parameter int          PROB_W = 8,
   parameter int          LFSR_W = 16,
   parameter logic [31:0] SEED   = 32'h0000_ACE1,
   localparam int         AW     = $clog2(NUM_TA),
   localparam int         SW     = $clog2(2 * HALF + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PROB_W:0] fb_prob,
   input  logic [AW-1:0]   rd_addr,
   output logic            rd_act,
   input  logic            inc_req,
   input  logic [AW-1:0]   inc_addr,
   input  logic            dec_req,
   input  logic [AW-1:0]   dec_addr
);
   if (NUM_TA < 2 || (1 << AW) != NUM_TA) begin : g_bad_depth
      $error("ta_bank: NUM_TA must be a power of two, at least 2");
   end
   if (HALF < 2) begin : g_bad_half
      $error("ta_bank: HALF must be at least 2");
   end
   if (LFSR_W < 2 * PROB_W) begin : g_bad_lfsr
      $error("ta_bank: LFSR_W must cover two PROB_W draws");
   end

   logic [LFSR_W-1:0]          lfsr_q;
   logic [NUM_TA-1:0][SW-1:0]  st_q;
   logic [NUM_TA-1:0]          act_v;
   logic                       clash, inc_go, dec_go;

   ta_lfsr #(.WIDTH(LFSR_W), .SEED(SEED)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .rnd(lfsr_q)
   );

   // Same-address pair cancels before the random gate.
   always_comb clash = inc_req && dec_req && (inc_addr == dec_addr);

   ta_gate #(.PROB_W(PROB_W)) u_gate_inc (
      .draw(lfsr_q[PROB_W-1:0]), .prob(fb_prob),
      .req(inc_req && !clash), .pass(inc_go)
   );
   ta_gate #(.PROB_W(PROB_W)) u_gate_dec (
      .draw(lfsr_q[2*PROB_W-1:PROB_W]), .prob(fb_prob),
      .req(dec_req && !clash), .pass(dec_go)
   );

   for (genvar i = 0; i < NUM_TA; i++) begin : g_cell
      logic up_i, dn_i;
      always_comb begin
         up_i = inc_go && (inc_addr == AW'(i));
         dn_i = dec_go && (dec_addr == AW'(i));
      end
      ta_cell #(.HALF(HALF), .SW(SW)) u_cell (
         .clk(clk), .rst_n(rst_n), .up(up_i), .dn(dn_i),
         .st(st_q[i]), .act(act_v[i])
      );
   end

   if (LFSR_W > 2 * PROB_W) begin : g_spare
      logic spare_unused;
      always_comb spare_unused = ^lfsr_q[LFSR_W-1:2*PROB_W];
   end

   always_comb rd_act = act_v[rd_addr];
endmodule

// File: rtl/ta_bank_chk.sv
module ta_bank_chk #(
   parameter int NUM_TA = 32,
   parameter int HALF   = 64,
   parameter int PROB_W = 8,
   parameter int LFSR_W = 16,
   parameter int AW     = 5,
   parameter int SW     = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [PROB_W:0]           fb_prob,
   input logic                      inc_req,
   input logic [AW-1:0]             inc_addr,
   input logic                      dec_req,
   input logic [AW-1:0]             dec_addr,
   input logic [LFSR_W-1:0]         lfsr_q,
   input logic [NUM_TA-1:0][SW-1:0] st_q
);
   localparam logic [PROB_W:0] FULL = (PROB_W + 1)'(1) << PROB_W;
   localparam logic [SW-1:0]   TOP  = SW'(2 * HALF);

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);                                                       // R11
   AST_LFSR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> lfsr_q != $past(lfsr_q));                           // R11
   AST_ZERO_PROB_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (fb_prob == '0 && inc_req) |=> st_q[$past(inc_addr)] == $past(st_q[inc_addr])); // R7
   AST_ZERO_PROB_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (fb_prob == '0 && dec_req) |=> st_q[$past(dec_addr)] == $past(st_q[dec_addr])); // R7
   AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_req && dec_req && inc_addr == dec_addr)
      |=> st_q[$past(inc_addr)] == $past(st_q[inc_addr]));                 // R9
   AST_FULL_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (fb_prob == FULL && inc_req && !(dec_req && dec_addr == inc_addr)
       && st_q[inc_addr] != TOP)
      |=> st_q[$past(inc_addr)] == $past(st_q[inc_addr]) + SW'(1));        // R3

   for (genvar i = 0; i < NUM_TA; i++) begin : g_rng
      AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         st_q[i] >= SW'(1) && st_q[i] <= TOP);                             // R5
   end
endmodule

bind ta_bank ta_bank_chk #(
   .NUM_TA(NUM_TA), .HALF(HALF), .PROB_W(PROB_W),
   .LFSR_W(LFSR_W), .AW(AW), .SW(SW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fb_prob(fb_prob),
   .inc_req(inc_req), .inc_addr(inc_addr),
   .dec_req(dec_req), .dec_addr(dec_addr),
   .lfsr_q(lfsr_q), .st_q(st_q)
);

// File: tb/ta_bank_tb.sv
module ta_bank_tb;
   localparam int NUM_TA = 32;
   localparam int HALF   = 64;
   localparam int PROB_W = 8;
   localparam int AW     = $clog2(NUM_TA);
   localparam logic [PROB_W:0] FULL  = 9'd256;
   localparam logic [PROB_W:0] HALFP = 9'd128;
   localparam logic [PROB_W:0] ZERO  = 9'd0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [PROB_W:0] fb_prob = '0;
   logic [AW-1:0] rd_addr = '0, inc_addr = '0, dec_addr = '0;
   logic inc_req = 1'b0, dec_req = 1'b0;
   logic rd_act;

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;
   bit   exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   ta_bank u_dut (
      .clk(clk), .rst_n(rst_n), .fb_prob(fb_prob),
      .rd_addr(rd_addr), .rd_act(rd_act),
      .inc_req(inc_req), .inc_addr(inc_addr),
      .dec_req(dec_req), .dec_addr(dec_addr)
   );

   function automatic void check(input bit ok, input string tag,
                                 input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endfunction

   // Monitor: one edge after the driver queued an item, compare the read.
   initial forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
         automatic bit    e = exp_q.pop_front();
         automatic string t = tag_q.pop_front();
         check(rd_act == e, t, int'(rd_act), int'(e));
      end
   end

   // Driver: one cycle of requests, plus an optional expected read.
   task automatic step(input bit iv, input int ia, input bit dv, input int da,
                       input logic [PROB_W:0] p, input int ra,
                       input bit chk, input bit exp, input string tag);
      @(negedge clk);
      inc_req  = iv;  inc_addr = AW'(ia);
      dec_req  = dv;  dec_addr = AW'(da);
      fb_prob  = p;   rd_addr  = AW'(ra);
      if (chk) begin
         exp_q.push_back(exp);
         tag_q.push_back(tag);
      end
      @(posedge clk);
      #1;
      inc_req = 1'b0;
      dec_req = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      int flips;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: every address starts at the midpoint, action 0
      for (int a = 0; a < NUM_TA; a++) step(0, 0, 0, 0, ZERO, a, 1, 0, "R1 reset midpoint");

      // R3, R12: one increment flips addr 3, neighbours untouched
      step(1, 3, 0, 0, FULL, 3, 1, 1, "R3 inc N->N+1");
      step(0, 0, 0, 0, ZERO, 2, 1, 0, "R12 neighbour 2 unchanged");
      step(0, 0, 0, 0, ZERO, 4, 1, 0, "R12 neighbour 4 unchanged");

      // R4, R2: walk down and back up through the threshold
      step(0, 0, 1, 3, FULL, 3, 1, 0, "R4 dec N+1->N");
      step(0, 0, 1, 3, FULL, 3, 1, 0, "R4 dec N->N-1");
      step(1, 3, 0, 0, FULL, 3, 1, 0, "R2 state N reads 0");
      step(1, 3, 0, 0, FULL, 3, 1, 1, "R2 state N+1 reads 1");

      // R7: zero probability blocks all requests (addr 3 at N+1)
      for (int k = 0; k < 10; k++) step(0, 0, 1, 3, ZERO, 3, 1, 1, "R7 zero prob dec");
      step(1, 9, 0, 0, ZERO, 9, 1, 0, "R7 zero prob inc");

      // R9: same-address pair cancels
      step(1, 5, 1, 5, FULL, 5, 1, 0, "R9 cancel at N");
      step(1, 5, 0, 0, FULL, 5, 1, 1, "R9 state was still N");
      step(1, 3, 1, 3, FULL, 3, 1, 1, "R9 cancel at N+1");
      step(0, 0, 1, 3, FULL, 3, 1, 0, "R9 state was still N+1");

      // R10: different addresses both apply in one cycle
      step(1, 7, 1, 8, FULL, 7, 1, 1, "R10 inc side applied");
      step(0, 0, 0, 0, ZERO, 8, 1, 0, "R10 dec side reads 0");
      step(1, 8, 0, 0, FULL, 8, 1, 0, "R10 dec side was N-1");

      // R5: saturate high, then count back down
      for (int k = 0; k < 100; k++) step(1, 10, 0, 0, FULL, 10, 0, 0, "");
      for (int k = 0; k < 62; k++) step(0, 0, 1, 10, FULL, 10, 0, 0, "");
      step(0, 0, 1, 10, FULL, 10, 1, 1, "R5 2N-63 reads 1");
      step(0, 0, 1, 10, FULL, 10, 1, 0, "R5 2N-64 reads 0");

      // R6: saturate low, then count back up
      for (int k = 0; k < 100; k++) step(0, 0, 1, 11, FULL, 11, 0, 0, "");
      for (int k = 0; k < 62; k++) step(1, 11, 0, 0, FULL, 11, 0, 0, "");
      step(1, 11, 0, 0, FULL, 11, 1, 0, "R6 1+63 reads 0");
      step(1, 11, 0, 0, FULL, 11, 1, 1, "R6 1+64 reads 1");

      // R8: half probability passes some but not all single steps
      flips = 0;
      for (int k = 0; k < 64; k++) begin
         step(1, 12, 0, 0, HALFP, 12, 0, 0, "");
         if (rd_act) begin
            flips++;
            step(0, 0, 1, 12, FULL, 12, 0, 0, "");
         end
      end
      check(flips >= 16 && flips <= 48, "R8 half prob pass count", flips, 32);
      step(0, 0, 0, 0, ZERO, 12, 1, 0, "R8 returned to N");

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule